// File: doc/BRIEF.md
# Motor Driver Fault and Power-State Supervisor

This block sits between the digital status flags of a single H-bridge power stage and the enables that drive it. It decides, every clock cycle, whether the bridge may conduct, whether the rest of the driver's logic must be held in reset, and whether the open-drain fault line must be pulled low. Its inputs are an active-low logic-reset request, an active-low sleep request, one current-limit flag per bridge switch, an over-temperature flag and an undervoltage flag. All of them arrive without a clock relationship and pass through a synchronizer first.

The block applies a different clearing rule to each protection event. A current limit must persist for a set number of cycles before it trips, and the trip then stays latched until a logic reset or an undervoltage event. Over-temperature trips at once and clears itself when the flag drops. Undervoltage and the logic-reset request hold the whole driver in reset. Leaving sleep starts a timer, and the bridge stays off until the timer expires. The fault output reports only the overcurrent and thermal conditions.

Top module: `mdrv_supervisor`

## Requirements
- R1: After the synchronous reset `rst`, `bridge_en` is 0, `fault_n` is 1 and `logic_rst` is 1, because the synchronized reset and sleep requests start out low.
- R2: The bridge runs only while both `rst_req_n` and `sleep_req_n` are high. If either one is low, `bridge_en` is 0.
- R3: If any bit of `oc_flag` stays high for OC_FILT_CYC consecutive synchronized cycles, the overcurrent trip latches. A run of OC_FILT_CYC-1 cycles does not latch it. A run broken by a cycle in which all flags are low restarts the count.
- R4: A latched overcurrent trip holds `bridge_en` at 0 and `fault_n` at 0 after the flags clear and across sleep cycles. Only `rst_req_n` low or `uv_flag` high clears it.
- R5: While the synchronized `ot_flag` is high, `bridge_en` is 0 and `fault_n` is 0. Both return to normal once the flag clears, without any reset.
- R6: While `uv_flag` is high, `logic_rst` is 1 and `bridge_en` is 0, and `fault_n` stays 1. A latched overcurrent trip is cleared. Operation resumes after the wake delay once the flag drops.
- R7: While `rst_req_n` is low, `logic_rst` is 1 and `bridge_en` is 0. Current-limit flags seen during that time do not latch a trip.
- R8: After the synchronized sleep request returns high with no other cause holding the bridge off, `bridge_en` rises exactly SYNC_STAGES+WAKE_CYC+1 clock edges after the input changes. It is still 0 one edge earlier.
- R9: `fault_n` is the inverse of (latched overcurrent OR synchronized over-temperature). Sleep, reset requests and undervoltage never pull it low by themselves.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Supervisor clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_req_n | input | 1 | Asynchronous active-low logic-reset request |
| sleep_req_n | input | 1 | Asynchronous active-low sleep request |
| oc_flag | input | NSW | Per-switch current-limit flags, asynchronous, active high |
| ot_flag | input | 1 | Over-temperature flag, asynchronous, active high |
| uv_flag | input | 1 | Supply undervoltage flag, asynchronous, active high |
| bridge_en | output | 1 | Registered enable for all bridge switches |
| logic_rst | output | 1 | Registered reset for the driver's internal logic, active high |
| fault_n | output | 1 | Fault indication, 0 means pull the open-drain line low |

## Verification
The bench builds the block with NSW=4, SYNC_STAGES=2, OC_FILT_CYC=6 and WAKE_CYC=20. With these values it can measure the wake delay to the exact edge. It also checks the overcurrent filter one cycle below and exactly at its threshold, and with a single-cycle gap inside a run. A short filter and timer let every clearing path run in turn within one short run: latch then reset, latch then undervoltage, latch across a sleep cycle, thermal self-clear, and flags raised during reset or sleep.

// File: rtl/mdrv_sup_pkg.sv
package mdrv_sup_pkg;

    // Synchronized control/status flags other than the per-switch limits
    typedef struct packed {
        logic uv;
        logic ot;
        logic sleep_n;
        logic rst_n;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    // Whole driver held in logic reset
    function automatic logic in_hold(input ctl_t c);
        return c.uv | ~c.rst_n;
    endfunction

    // Bridge may conduct given the live inputs and the latched trip
    function automatic logic may_run(input ctl_t c, input logic trip, input logic ready);
        return ready & ~trip & ~c.ot & c.sleep_n & ~in_hold(c);
    endfunction

endpackage

// File: rtl/mdrv_sync.sv
module mdrv_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[gi] <= '0;
                    else     stg[gi] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[gi] <= '0;
                    else     stg[gi] <= stg[gi-1];
                end
            end
        end
    endgenerate

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/mdrv_oc_filter.sv
module mdrv_oc_filter #(
    parameter int NSW  = 4,
    parameter int FILT = 300
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clr,
    input  logic           gate,
    input  logic [NSW-1:0] oc,
    output logic           tripped
);
    localparam int CW = $clog2(FILT + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT - 1);

    logic [CW-1:0] cnt;
    logic          any_oc;

    assign any_oc = |oc;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt     <= '0;
            tripped <= 1'b0;
        end else if (tripped) begin
            cnt <= '0;
        end else if (gate && any_oc) begin
            if (cnt == LAST) begin
                tripped <= 1'b1;
                cnt     <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else begin
            cnt <= '0;
        end
    end

    // R4
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        tripped && !clr |=> tripped);

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

    // R3
    no_early_trip_chk: assert property (@(posedge clk) disable iff (rst)
        !tripped && !any_oc && !clr |=> !tripped);
endmodule

// File: rtl/mdrv_wake_timer.sv
module mdrv_wake_timer #(
    parameter int WAKE = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic ready
);
    localparam int CW = $clog2(WAKE + 1);
    localparam logic [CW-1:0] DONE = CW'(WAKE);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)     cnt <= '0;
        else if (cnt != DONE) cnt <= cnt + 1'b1;
    end

    assign ready = (cnt == DONE);

    // R8
    wake_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> !ready);

    // R8
    wake_stay_chk: assert property (@(posedge clk) disable iff (rst)
        ready && run |=> ready);
endmodule

// File: rtl/mdrv_supervisor.sv
module mdrv_supervisor
    import mdrv_sup_pkg::*;
#(
    parameter int NSW         = 4,
    parameter int SYNC_STAGES = 2,
    parameter int OC_FILT_CYC = 300,
    parameter int WAKE_CYC    = 100000
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           rst_req_n,
    input  logic           sleep_req_n,
    input  logic [NSW-1:0] oc_flag,
    input  logic           ot_flag,
    input  logic           uv_flag,
    output logic           bridge_en,
    output logic           logic_rst,
    output logic           fault_n
);
    localparam int SYNC_W = NSW + CTL_W;

    logic [SYNC_W-1:0] raw_vec;
    logic [SYNC_W-1:0] syn_vec;
    ctl_t              ctl;
    logic [NSW-1:0]    oc_s;
    logic              hold;
    logic              trip;
    logic              ready;

    assign raw_vec = {uv_flag, ot_flag, sleep_req_n, rst_req_n, oc_flag};

    mdrv_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (raw_vec),
        .dout(syn_vec)
    );

    assign ctl  = ctl_t'(syn_vec[SYNC_W-1:NSW]);
    assign oc_s = syn_vec[NSW-1:0];
    assign hold = in_hold(ctl);

    mdrv_oc_filter #(.NSW(NSW), .FILT(OC_FILT_CYC)) u_oc (
        .clk    (clk),
        .rst    (rst),
        .clr    (hold),
        .gate   (ctl.sleep_n),
        .oc     (oc_s),
        .tripped(trip)
    );

    mdrv_wake_timer #(.WAKE(WAKE_CYC)) u_wake (
        .clk  (clk),
        .rst  (rst),
        .run  (ctl.sleep_n & ~hold),
        .ready(ready)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bridge_en <= 1'b0;
            logic_rst <= 1'b1;
            fault_n   <= 1'b1;
        end else begin
            bridge_en <= may_run(ctl, trip, ready);
            logic_rst <= hold;
            fault_n   <= ~(trip | ctl.ot);
        end
    end

    // R4
    trip_fault_chk: assert property (@(posedge clk) disable iff (rst)
        trip |=> !fault_n && !bridge_en);

    // R5
    ot_off_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.ot |=> !fault_n && !bridge_en);

    // R2
    sleep_off_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl.sleep_n |=> !bridge_en);

    // R6
    hold_rst_chk: assert property (@(posedge clk) disable iff (rst)
        hold |=> logic_rst && !bridge_en);

    // R9
    quiet_fault_chk: assert property (@(posedge clk) disable iff (rst)
        !trip && !ctl.ot |=> fault_n);
endmodule

// File: tb/mdrv_supervisor_tb.sv
module mdrv_supervisor_tb;
    localparam int NSW  = 4;
    localparam int SYNC = 2;
    localparam int FILT = 6;
    localparam int WAKE = 20;

    logic           clk = 1'b0;
    logic           rst;
    logic           rst_req_n;
    logic           sleep_req_n;
    logic [NSW-1:0] oc_flag;
    logic           ot_flag;
    logic           uv_flag;
    logic           bridge_en;
    logic           logic_rst;
    logic           fault_n;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    mdrv_supervisor #(
        .NSW(NSW), .SYNC_STAGES(SYNC), .OC_FILT_CYC(FILT), .WAKE_CYC(WAKE)
    ) u_dut (
        .clk        (clk),
        .rst        (rst),
        .rst_req_n  (rst_req_n),
        .sleep_req_n(sleep_req_n),
        .oc_flag    (oc_flag),
        .ot_flag    (ot_flag),
        .uv_flag    (uv_flag),
        .bridge_en  (bridge_en),
        .logic_rst  (logic_rst),
        .fault_n    (fault_n)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic settle_run();
        step(SYNC + WAKE + 4);
    endtask

    task automatic t_reset();
        rst = 1'b1; rst_req_n = 1'b0; sleep_req_n = 1'b0;
        oc_flag = '0; ot_flag = 1'b0; uv_flag = 1'b0;
        step(3);
        rst = 1'b0;
        step(1);
        chk("R1 bridge_en", bridge_en, 1'b0);
        chk("R1 fault_n", fault_n, 1'b1);
        chk("R1 logic_rst", logic_rst, 1'b1);
    endtask

    task automatic t_wake();
        rst_req_n = 1'b1;
        step(SYNC + 4);
        chk("R7 logic_rst released", logic_rst, 1'b0);
        chk("R2 sleep low keeps bridge off", bridge_en, 1'b0);
        sleep_req_n = 1'b1;
        step(SYNC + WAKE);
        chk("R8 one edge before wake", bridge_en, 1'b0);
        step(1);
        chk("R8 at wake edge", bridge_en, 1'b1);
    endtask

    task automatic t_oc_short();
        oc_flag[1] = 1'b1;
        step(FILT - 1);
        oc_flag[1] = 1'b0;
        step(6);
        chk("R3 short run no trip fault_n", fault_n, 1'b1);
        chk("R3 short run no trip bridge", bridge_en, 1'b1);
        oc_flag[0] = 1'b1; step(FILT - 1);
        oc_flag[0] = 1'b0; step(1);
        oc_flag[3] = 1'b1; step(FILT - 1);
        oc_flag[3] = 1'b0;
        step(6);
        chk("R3 broken run restarts count", fault_n, 1'b1);
    endtask

    task automatic trip_oc();
        oc_flag[2] = 1'b1;
        step(FILT);
        oc_flag[2] = 1'b0;
        step(6);
    endtask

    task automatic t_oc_latch_rst();
        trip_oc();
        chk("R3 full run trips fault_n", fault_n, 1'b0);
        chk("R3 full run trips bridge", bridge_en, 1'b0);
        step(10);
        chk("R4 latched after flags clear", fault_n, 1'b0);
        rst_req_n = 1'b0;
        step(SYNC + 2);
        chk("R7 logic_rst during request", logic_rst, 1'b1);
        chk("R4 reset clears trip", fault_n, 1'b1);
        chk("R7 bridge off during request", bridge_en, 1'b0);
        rst_req_n = 1'b1;
        settle_run();
        chk("R4 resumes after reset", bridge_en, 1'b1);
    endtask

    task automatic t_oc_sleep_uv();
        trip_oc();
        sleep_req_n = 1'b0; step(SYNC + 3);
        sleep_req_n = 1'b1; settle_run();
        chk("R4 trip survives sleep", fault_n, 1'b0);
        chk("R4 bridge off after sleep", bridge_en, 1'b0);
        uv_flag = 1'b1;
        step(SYNC + 2);
        chk("R6 logic_rst in undervoltage", logic_rst, 1'b1);
        chk("R6 bridge off in undervoltage", bridge_en, 1'b0);
        chk("R6 uv does not pull fault", fault_n, 1'b1);
        uv_flag = 1'b0;
        settle_run();
        chk("R6 resume after uv", bridge_en, 1'b1);
        chk("R6 logic_rst released", logic_rst, 1'b0);
    endtask

    task automatic t_thermal();
        ot_flag = 1'b1;
        step(SYNC + 2);
        chk("R5 thermal fault_n", fault_n, 1'b0);
        chk("R5 thermal bridge", bridge_en, 1'b0);
        ot_flag = 1'b0;
        step(SYNC + 2);
        chk("R5 thermal self clear fault_n", fault_n, 1'b1);
        chk("R5 thermal self clear bridge", bridge_en, 1'b1);
    endtask

    task automatic t_ignored();
        rst_req_n = 1'b0;
        step(SYNC + 1);
        oc_flag = '1;
        step(3 * FILT);
        oc_flag = '0;
        step(SYNC + 1);
        rst_req_n = 1'b1;
        settle_run();
        chk("R7 flags ignored in reset", fault_n, 1'b1);
        chk("R7 bridge runs after reset", bridge_en, 1'b1);
        sleep_req_n = 1'b0;
        step(SYNC + 1);
        oc_flag = '1;
        step(3 * FILT);
        chk("R9 sleep does not pull fault", fault_n, 1'b1);
        chk("R2 sleep bridge off", bridge_en, 1'b0);
        oc_flag = '0;
        step(SYNC + 1);
        sleep_req_n = 1'b1;
        settle_run();
        chk("R9 no fault after sleep", fault_n, 1'b1);
        chk("R2 bridge back after sleep", bridge_en, 1'b1);
    endtask

    initial begin
        t_reset();
        t_wake();
        t_oc_short();
        t_oc_latch_rst();
        t_oc_sleep_uv();
        t_thermal();
        t_ignored();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule